// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is a direct-mapped cache controller for one processor that shares a single bus with other caching processors. It keeps its lines coherent by watching every transaction the other caches put on the bus. Each line carries three state bits: valid, dirty and shared. The processor issues reads and writes. The controller completes hits locally where the coherence state allows it. Otherwise it raises a bus request carrying a read-miss, write-miss, invalidate or write-back command and waits for a grant. A transaction completes in the cycle it is granted, and memory returns line data in that same cycle.

On the snoop side, the block observes the command and address of each transaction from another cache. When a matching valid line is asked for by a remote miss, it drives the line onto a supply output in the same cycle. It then updates the line state at the next clock edge. Snooped traffic always takes precedence: a processor request stalls while a snoop is present. The memory, the arbiter and the other caches sit outside the block.

Top module: `snoop_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any index misses and requests the bus.
- R2: A read whose tag matches a valid line completes in the same cycle with cpu_ready high, returns the line data, and raises no bus request.
- R3: A read miss with a clean or invalid victim requests the bus with command 0 (read miss) and the processor address. The grant cycle completes the read with bus_rdata. The line is then valid, clean and shared.
- R4: A write miss with a clean or invalid victim requests command 1 (write miss). In the grant cycle the fetched line is merged with the write data, where enable bit k selects bits 8k+7..8k, and the write completes. The line is then valid, dirty and not shared.
- R5: A write hit on a line whose shared bit is 0 completes in the same cycle with no bus request. It merges the enabled bytes and leaves the line dirty and not shared, so repeated writes stay silent.
- R6: A write hit on a shared line requests command 2 (invalidate) and completes on its grant. The line ends dirty and not shared.
- R7: A miss whose victim line is valid and dirty first requests command 3 (write-back). This request carries address {victim tag, index} and the victim data, and the processor is not released. After the grant the victim is clean, and the miss proceeds as in R3 or R4.
- R8: A snooped command 0 whose address (tag bits 5..2, index bits 1..0) matches a valid line raises snp_supply with that line's data in the same cycle. It then sets the line's shared bit.
- R9: A snooped command 1 matching a valid line supplies the line data in the same cycle and then invalidates the line.
- R10: A snooped command 2 or 3 matching a valid line invalidates it without supplying data.
- R11: A snooped transaction whose tag differs from the line at its index, or whose line is invalid, changes no state and supplies nothing.
- R12: While snp_valid is high, bus_req and cpu_ready stay low, so the snoop is serviced before any processor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | TAG_W+IDX_W | Processor address: tag high, index low |
| cpu_wdata | input | DATA_W | Write data |
| cpu_be | input | DATA_W/8 | Byte enables for writes |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready on reads |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | 0 read miss, 1 write miss, 2 invalidate, 3 write-back |
| bus_addr | output | TAG_W+IDX_W | Transaction address |
| bus_wdata | output | DATA_W | Victim data for write-back |
| bus_gnt | input | 1 | Grant; the transaction completes this cycle |
| bus_rdata | input | DATA_W | Line data from memory in the grant cycle |
| snp_valid | input | 1 | A transaction from another cache is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | TAG_W+IDX_W | Snooped address |
| snp_supply | output | 1 | This cache supplies the snooped line |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The assertions assume the arbiter grants only while this cache requests, and never grants during a cycle carrying a snooped transaction. They also assume the processor holds its request steady until it is released. The bench keeps to these rules by driving the grant from its own model's expected request, so a grant never coincides with a snoop. Each processor operation is held until the model predicts completion, with a varying number of refused grant cycles. A reference model of the line states and of memory predicts every output on every cycle, across directed coherence sequences and a random mix of processor and snoop traffic.

// File: rtl/snoop_cache.sv
module snoop_cache #(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [TAG_W+IDX_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [DATA_W/8-1:0]     cpu_be,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    bus_req,
  output logic [1:0]              bus_cmd,
  output logic [TAG_W+IDX_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    bus_gnt,
  input  logic [DATA_W-1:0]       bus_rdata,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [TAG_W+IDX_W-1:0]  snp_addr,
  output logic                    snp_supply,
  output logic [DATA_W-1:0]       snp_data
);
  localparam int ADDR_W = TAG_W + IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int BE_W   = DATA_W / 8;
  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_INV = 2'd2;
  localparam logic [1:0] OP_WB  = 2'd3;

  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];
  logic [LINES-1:0]  vld_q, dty_q, shr_q;

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire c_hit = vld_q[c_idx] && (tag_q[c_idx] == c_tag);
  wire s_hit = vld_q[s_idx] && (tag_q[s_idx] == s_tag);
  wire c_go  = cpu_req && !snp_valid;

  logic       need_bus;
  logic [1:0] op;

  always_comb begin
    need_bus = 1'b1;
    op       = OP_RD;
    if (c_hit) begin
      if (!cpu_we || !shr_q[c_idx]) need_bus = 1'b0;
      else                          op       = OP_INV;
    end else if (vld_q[c_idx] && dty_q[c_idx]) begin
      op = OP_WB;
    end else begin
      op = cpu_we ? OP_WR : OP_RD;
    end
  end

  assign bus_req   = c_go && need_bus;
  assign bus_cmd   = op;
  assign bus_addr  = (op == OP_WB) ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = data_q[c_idx];
  assign cpu_ready = c_go && (!need_bus || (bus_gnt && op != OP_WB));

  wire [DATA_W-1:0] base = c_hit ? data_q[c_idx] : bus_rdata;
  logic [DATA_W-1:0] merged;

  for (genvar b = 0; b < BE_W; b++) begin : g_byte
    assign merged[8*b +: 8] = cpu_be[b] ? cpu_wdata[8*b +: 8] : base[8*b +: 8];
  end

  assign cpu_rdata  = base;
  assign snp_supply = snp_valid && s_hit && !snp_cmd[1];
  assign snp_data   = data_q[s_idx];

  wire fill    = cpu_ready && (cpu_we || !c_hit);
  wire wb_done = bus_req && bus_gnt && (op == OP_WB);

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[c_idx]  <= c_tag;
      data_q[c_idx] <= cpu_we ? merged : bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
      shr_q <= '0;
    end else if (snp_valid) begin
      if (s_hit) begin
        if (snp_cmd == OP_RD) begin
          shr_q[s_idx] <= 1'b1;
        end else begin
          vld_q[s_idx] <= 1'b0;
          dty_q[s_idx] <= 1'b0;
          shr_q[s_idx] <= 1'b0;
        end
      end
    end else if (fill) begin
      vld_q[c_idx] <= 1'b1;
      dty_q[c_idx] <= cpu_we;
      shr_q[c_idx] <= !cpu_we;
    end else if (wb_done) begin
      dty_q[c_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/snoop_cache_chk.sv
module snoop_cache_chk #(
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_req,
  input logic                   cpu_we,
  input logic [TAG_W+IDX_W-1:0] cpu_addr,
  input logic                   cpu_ready,
  input logic                   bus_req,
  input logic [1:0]             bus_cmd,
  input logic [TAG_W+IDX_W-1:0] bus_addr,
  input logic                   bus_gnt,
  input logic                   snp_valid,
  input logic [1:0]             snp_cmd,
  input logic                   snp_supply
);
  // R12
  snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !cpu_ready));

  // R2
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req);

  // R3
  rdmiss_is_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd0) |-> (!cpu_we && bus_addr == cpu_addr));

  // R4
  wrmiss_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd1) |-> (cpu_we && bus_addr == cpu_addr));

  // R6
  inv_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd2) |-> (cpu_we && cpu_ready));

  // R7
  wb_holds_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd3) |-> (!cpu_ready &&
      bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]));

  // R7
  wb_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_req && bus_gnt && bus_cmd == 2'd3) && bus_req &&
     bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0])) |-> (bus_cmd != 2'd3));

  // R8
  supply_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && !snp_cmd[1]));

  // R10
  no_supply_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd[1]) |-> !snp_supply);
endmodule

bind snoop_cache snoop_cache_chk #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_supply(snp_supply)
);

// File: tb/tb_snoop_cache.sv
module tb_snoop_cache;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [5:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        bus_req;
  logic [1:0]  bus_cmd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_gnt;
  logic [31:0] bus_rdata;
  logic        snp_valid;
  logic [1:0]  snp_cmd;
  logic [5:0]  snp_addr;
  logic        snp_supply;
  logic [31:0] snp_data;

  snoop_cache dut (.*);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_tag [4];
  logic [31:0] m_dat [4];
  bit          m_v [4], m_d [4], m_s [4];
  logic [31:0] mem [64];
  bit          last_ready;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mrg(logic [31:0] old, logic [31:0] wd, logic [3:0] be);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = wd[8*k +: 8];
    return r;
  endfunction

  task automatic step(bit req, bit we, logic [5:0] a, logic [31:0] wd, logic [3:0] be,
                      bit sv, logic [1:0] sc, logic [5:0] sa, bit allow, string ovr);
    int ci, si;
    bit hit, s_hit, e_req, e_rdy, e_sup;
    logic [1:0] e_cmd;
    logic [5:0] e_addr;
    string tg;
    @(negedge clk);
    ci = int'(a[1:0]);
    si = int'(sa[1:0]);
    hit   = m_v[ci] && m_tag[ci] == a[5:2];
    s_hit = m_v[si] && m_tag[si] == sa[5:2];
    e_req = 0; e_rdy = 0; e_cmd = 0; e_addr = a; tg = "R2";
    if (req && !sv) begin
      if (hit && !we)        begin e_rdy = 1; tg = "R2"; end
      else if (hit && !m_s[ci]) begin e_rdy = 1; tg = "R5"; end
      else if (hit)          begin e_req = 1; e_cmd = 2; tg = "R6"; end
      else if (m_v[ci] && m_d[ci]) begin e_req = 1; e_cmd = 3; e_addr = {m_tag[ci], a[1:0]}; tg = "R7"; end
      else begin e_req = 1; e_cmd = we ? 2'd1 : 2'd0; tg = we ? "R4" : "R3"; end
      if (e_req && allow && e_cmd != 3) e_rdy = 1;
    end
    if (sv) tg = "R12";
    if (ovr != "") tg = ovr;
    e_sup = sv && s_hit && sc[1] == 1'b0;
    cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    snp_valid = sv; snp_cmd = sc; snp_addr = sa;
    bus_gnt = e_req && allow;
    bus_rdata = mem[e_addr];
    #2;
    chk(tg, "cpu_ready", {31'd0, cpu_ready}, {31'd0, e_rdy});
    chk(tg, "bus_req", {31'd0, bus_req}, {31'd0, e_req});
    if (e_req) begin
      chk(tg, "bus_cmd", {30'd0, bus_cmd}, {30'd0, e_cmd});
      chk(tg, "bus_addr", {26'd0, bus_addr}, {26'd0, e_addr});
      if (e_cmd == 3) chk(tg, "bus_wdata", bus_wdata, m_dat[ci]);
    end
    if (e_rdy && !we) chk(tg, "cpu_rdata", cpu_rdata, hit ? m_dat[ci] : mem[a]);
    if (sv) begin
      tg = !s_hit ? "R11" : (sc == 0 ? "R8" : (sc == 1 ? "R9" : "R10"));
      if (ovr != "") tg = ovr;
      chk(tg, "snp_supply", {31'd0, snp_supply}, {31'd0, e_sup});
      if (e_sup) chk(tg, "snp_data", snp_data, m_dat[si]);
    end
    // model update for the coming edge
    if (sv) begin
      if (s_hit) begin
        if (sc == 0) m_s[si] = 1;
        else begin m_v[si] = 0; m_d[si] = 0; m_s[si] = 0; end
      end
      if (sc == 3) mem[sa] = mem[sa] ^ 32'h0F0F_1234;
    end else if (e_rdy) begin
      if (we) begin
        m_dat[ci] = mrg(hit ? m_dat[ci] : mem[a], wd, be);
        m_tag[ci] = a[5:2]; m_v[ci] = 1; m_d[ci] = 1; m_s[ci] = 0;
      end else if (!hit) begin
        m_dat[ci] = mem[a]; m_tag[ci] = a[5:2]; m_v[ci] = 1; m_d[ci] = 0; m_s[ci] = 1;
      end
    end else if (e_req && allow && e_cmd == 3) begin
      mem[e_addr] = m_dat[ci];
      m_d[ci] = 0;
    end
    last_ready = e_rdy;
  endtask

  task automatic cpu_op(bit we, logic [5:0] a, logic [31:0] wd, logic [3:0] be, int wait_n, string ovr);
    for (int k = 0; k < 40; k++) begin
      step(1, we, a, wd, be, 0, 2'd0, 6'd0, k >= wait_n, (k == 0) ? ovr : "");
      if (last_ready) break;
    end
  endtask

  task automatic snoop(logic [1:0] c, logic [5:0] a, bit with_cpu, logic [5:0] ca, string ovr);
    step(with_cpu, 1'b1, ca, 32'hDEAD_BEEF, 4'hF, 1, c, a, 1, ovr);
  endtask

  task automatic idle();
    step(0, 0, 6'd0, 32'd0, 4'd0, 0, 2'd0, 6'd0, 0, "");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h1357_0000 + i * 32'h0001_0203;
    for (int i = 0; i < 4; i++) begin m_v[i] = 0; m_d[i] = 0; m_s[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0; cpu_be = 0;
    bus_gnt = 0; bus_rdata = 0; snp_valid = 0; snp_cmd = 0; snp_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    idle();
    // R1: every index misses after reset
    for (int i = 0; i < 4; i++) cpu_op(0, {4'(i + 1), 2'(i)}, 32'd0, 4'd0, 2, "R1");
    // R2: read hits
    for (int i = 0; i < 4; i++) cpu_op(0, {4'(i + 1), 2'(i)}, 32'd0, 4'd0, 0, "R2");
    // R6 then R5: upgrade a shared line, then silent writes
    cpu_op(1, 6'b0001_00, 32'hAABB_CCDD, 4'b0101, 1, "R6");
    cpu_op(1, 6'b0001_00, 32'h1122_3344, 4'b1000, 0, "R5");
    cpu_op(1, 6'b0001_00, 32'h5566_7788, 4'b0010, 0, "R5");
    cpu_op(0, 6'b0001_00, 32'd0, 4'd0, 0, "R5");
    // R7 then R4: dirty victim written back, then write miss
    cpu_op(1, 6'b1001_00, 32'hCAFE_F00D, 4'b0011, 2, "R7");
    cpu_op(0, 6'b1001_00, 32'd0, 4'd0, 0, "R4");
    // R4: write miss over a clean victim
    cpu_op(1, 6'b1100_01, 32'h0BAD_F00D, 4'b1100, 1, "R4");
    // R3 with dirty victim: read miss after write-back
    cpu_op(0, 6'b0001_00, 32'd0, 4'd0, 1, "R7");
    // R8: snoop read of dirty line, line becomes shared
    cpu_op(1, 6'b0100_11, 32'h7777_8888, 4'hF, 0, "R6");
    snoop(0, 6'b0100_11, 1, 6'b0100_11, "R8");
    cpu_op(1, 6'b0100_11, 32'h9999_AAAA, 4'b0001, 1, "R8");
    // R12: snoop during processor request
    snoop(2'd0, 6'b1111_10, 1, 6'b0011_10, "R12");
    // R9: snoop write miss supplies then invalidates
    snoop(1, 6'b0100_11, 0, 6'd0, "R9");
    cpu_op(0, 6'b0100_11, 32'd0, 4'd0, 0, "R9");
    // R10: invalidate and write-back snoops
    snoop(2, 6'b0011_10, 0, 6'd0, "R10");
    cpu_op(0, 6'b0011_10, 32'd0, 4'd0, 0, "R10");
    snoop(3, 6'b1100_01, 0, 6'd0, "R10");
    cpu_op(1, 6'b1100_01, 32'h3141_5926, 4'hF, 0, "R10");
    // R11: non-matching snoops leave state alone
    snoop(1, 6'b0000_01, 0, 6'd0, "R11");
    snoop(2, 6'b1111_01, 0, 6'd0, "R11");
    cpu_op(1, 6'b1100_01, 32'h2718_2818, 4'b0110, 0, "R11");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [5:0] ra;
      ra = {2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
      if ($urandom_range(0, 3) == 0)
        snoop(2'($urandom_range(0, 3)), ra, $urandom_range(0, 1) == 1, 6'(ra + 6'd5), "");
      else
        cpu_op($urandom_range(0, 1) == 1, ra, $urandom, 4'($urandom_range(0, 15)),
               $urandom_range(0, 3), "");
    end
    idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule